// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired controller for a multicycle load/store processor datapath. A 4-bit state register holds the current step of the instruction. Combinational logic takes that state and the 6-bit opcode from the instruction register. From those two inputs it produces the next state and every datapath strobe for the current cycle. The strobes cover program-counter writes, instruction-register load, memory access, ALU operand and operation selection, register-file write and immediate extension. The datapath, the memories and the register file are outside this block.

The next-state and output logic is built as a two-plane product-term array. Each row of the AND plane matches one exact state and either one opcode or any opcode. Each row carries a full output word into the OR plane. A state with several successors gets one row per decoded opcode. At most one row fires for any input, so the OR plane simply passes the selected row through. When no row matches, the result is the all-zero word: next state fetch with every strobe low. That is how unknown opcodes and unused states fall back to fetch.

Opcodes: load `100011`, store `101011`, register-register `000000`, branch-equal `000100`, jump `000010`, OR-immediate `001101`.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `state` becomes 0 (fetch). The reset is synchronous.
- R2: In state 0, for any opcode, `pc_write`=1, `ir_write`=1, `alu_src_b`=01 and `pc_source`=00. Every other strobe is 0 and `next_state`=1.
- R3: In state 1 with a recognised opcode, `alu_src_b`=11 and `ext_op`=1, and every other strobe is 0. `next_state` is 2 for load or store, 6 for register-register, 8 for branch, 9 for jump and 10 for OR-immediate.
- R4: In state 1 with any other opcode, every strobe is 0 and `next_state`=0.
- R5: A load visits states 0,1,2,3,4,0. State 2 drives `alu_src_a`=1, `alu_src_b`=10 and `ext_op`=1. State 3 drives `iord`=1. State 4 drives `reg_write`=1 and `mem_to_reg`=1.
- R6: A store visits states 0,1,2,5,0. State 2 drives the same strobes as for a load. State 5 drives `iord`=1 and `mem_write`=1.
- R7: A register-register operation visits states 1,6,7,0. State 6 drives `alu_src_a`=1 and `alu_op`=10. State 7 drives `reg_write`=1 and `reg_dst`=1.
- R8: A branch visits states 1,8,0. State 8 drives `alu_src_a`=1, `alu_op`=01, `pc_write_cond`=1 and `pc_source`=01.
- R9: A jump visits states 1,9,0. State 9 drives `pc_write`=1 and `pc_source`=10, and every other strobe is 0.
- R10: An OR-immediate visits states 1,10,11,0. State 10 drives `alu_src_a`=1, `alu_src_b`=10, `alu_op`=11 and `ext_op`=0. State 11 drives `reg_write`=1.
- R11: `reg_write` is high only in states 4, 7 and 11.
- R12: At most one product term is selected in any cycle. If none is selected, every strobe is 0 and `next_state`=0. In particular, state 2 with an opcode other than load or store returns to fetch with all strobes low.
- R13: On every rising edge with `rst_n` high, `state` takes the value `next_state` had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Opcode field from the instruction register |
| state | output | 4 | Current state |
| next_state | output | 4 | State to be loaded at the next edge |
| pc_write | output | 1 | Unconditional PC write |
| pc_write_cond | output | 1 | PC write qualified by ALU zero |
| iord | output | 1 | Memory address from ALU result rather than PC |
| mem_write | output | 1 | Memory write strobe |
| ir_write | output | 1 | Instruction register load |
| mem_to_reg | output | 1 | Register write data from memory data register |
| pc_source | output | 2 | New PC: 00 ALU, 01 ALU-out register, 10 jump target |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field, 11 OR |
| alu_src_b | output | 2 | 00 B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_src_a | output | 1 | ALU A from register A rather than PC |
| reg_write | output | 1 | Register file write strobe |
| reg_dst | output | 1 | Destination from rd rather than rt |
| ext_op | output | 1 | Sign-extend immediate (0 = zero-extend) |

## Verification
The assertions check several properties on every cycle. At most one product term is active. An empty selection yields an all-zero word. The register-file write appears only in its three write-back states. Fetch and jump-completion strobes are as specified. The state register follows the next-state output, and reset lands in fetch. Only the bench's instruction scenarios can show whole paths per opcode. Those include the load, store and immediate sequences, unknown opcodes in decode and in address calculation, and a reset taken in mid-instruction. A random opcode stream checks every output against an independent model in every reachable state.

// File: rtl/mc_ctrl_pkg.sv
// Package: shared widths, opcode codes, state numbers, the control word
// and the product-term table of the controller.
// Assumes: the opcode is stable for the whole instruction (held in IR).
package mc_ctrl_pkg;

    localparam int ST_W     = 4;
    localparam int OP_W     = 6;
    localparam int N_TERMS  = 18;

    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OPC_RR    = 6'b000000;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'b001101;

    localparam logic [OP_W-1:0] CARE_ALL  = '1;
    localparam logic [OP_W-1:0] CARE_NONE = '0;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_ADDR    = 4'd2,
        ST_MEMRD   = 4'd3,
        ST_LDWB    = 4'd4,
        ST_MEMWR   = 4'd5,
        ST_RREXE   = 4'd6,
        ST_RRWB    = 4'd7,
        ST_BRANCH  = 4'd8,
        ST_JUMP    = 4'd9,
        ST_IMMEXE  = 4'd10,
        ST_IMMWB   = 4'd11
    } st_e;

    // Datapath strobes, most significant first
    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       iord;
        logic       mem_wr;
        logic       ir_wr;
        logic       mem_to_reg;
        logic [1:0] pc_src;
        logic [1:0] alu_op;
        logic [1:0] alu_src_b;
        logic       alu_src_a;
        logic       reg_wr;
        logic       reg_dst;
        logic       ext_op;
    } ctrl_t;

    // One row of the array: AND-plane match fields, OR-plane outputs
    typedef struct packed {
        logic [ST_W-1:0] st;
        logic [OP_W-1:0] op;
        logic [OP_W-1:0] care;
        logic [ST_W-1:0] ns;
        ctrl_t           ctrl;
    } term_t;

    typedef term_t [N_TERMS-1:0] plane_t;

    function automatic term_t mk_term(input st_e st, input logic [OP_W-1:0] op,
                                      input logic [OP_W-1:0] care, input st_e ns,
                                      input ctrl_t ctrl);
        term_t t;
        t.st   = st;
        t.op   = op & care;
        t.care = care;
        t.ns   = ns;
        t.ctrl = ctrl;
        return t;
    endfunction

    // Builds the full product-term table; don't-care strobes are left at 0
    function automatic plane_t build_plane();
        plane_t p;
        ctrl_t  c_fetch, c_dec, c_addr, c_rd, c_ldwb, c_wr, c_rrx, c_rrwb;
        ctrl_t  c_br, c_jmp, c_imx, c_imwb;
        c_fetch = '0; c_fetch.pc_wr = 1'b1; c_fetch.ir_wr = 1'b1; c_fetch.alu_src_b = 2'b01;
        c_dec   = '0; c_dec.alu_src_b = 2'b11; c_dec.ext_op = 1'b1;
        c_addr  = '0; c_addr.alu_src_a = 1'b1; c_addr.alu_src_b = 2'b10; c_addr.ext_op = 1'b1;
        c_rd    = '0; c_rd.iord = 1'b1;
        c_ldwb  = '0; c_ldwb.reg_wr = 1'b1; c_ldwb.mem_to_reg = 1'b1;
        c_wr    = '0; c_wr.iord = 1'b1; c_wr.mem_wr = 1'b1;
        c_rrx   = '0; c_rrx.alu_src_a = 1'b1; c_rrx.alu_op = 2'b10;
        c_rrwb  = '0; c_rrwb.reg_wr = 1'b1; c_rrwb.reg_dst = 1'b1;
        c_br    = '0; c_br.alu_src_a = 1'b1; c_br.alu_op = 2'b01;
                      c_br.pc_wr_cond = 1'b1; c_br.pc_src = 2'b01;
        c_jmp   = '0; c_jmp.pc_wr = 1'b1; c_jmp.pc_src = 2'b10;
        c_imx   = '0; c_imx.alu_src_a = 1'b1; c_imx.alu_src_b = 2'b10; c_imx.alu_op = 2'b11;
        c_imwb  = '0; c_imwb.reg_wr = 1'b1;
        p[0]  = mk_term(ST_FETCH,  '0,        CARE_NONE, ST_DECODE, c_fetch);
        p[1]  = mk_term(ST_DECODE, OPC_LOAD,  CARE_ALL,  ST_ADDR,   c_dec);
        p[2]  = mk_term(ST_DECODE, OPC_STORE, CARE_ALL,  ST_ADDR,   c_dec);
        p[3]  = mk_term(ST_DECODE, OPC_RR,    CARE_ALL,  ST_RREXE,  c_dec);
        p[4]  = mk_term(ST_DECODE, OPC_BEQ,   CARE_ALL,  ST_BRANCH, c_dec);
        p[5]  = mk_term(ST_DECODE, OPC_JUMP,  CARE_ALL,  ST_JUMP,   c_dec);
        p[6]  = mk_term(ST_DECODE, OPC_ORI,   CARE_ALL,  ST_IMMEXE, c_dec);
        p[7]  = mk_term(ST_ADDR,   OPC_LOAD,  CARE_ALL,  ST_MEMRD,  c_addr);
        p[8]  = mk_term(ST_ADDR,   OPC_STORE, CARE_ALL,  ST_MEMWR,  c_addr);
        p[9]  = mk_term(ST_MEMRD,  '0,        CARE_NONE, ST_LDWB,   c_rd);
        p[10] = mk_term(ST_LDWB,   '0,        CARE_NONE, ST_FETCH,  c_ldwb);
        p[11] = mk_term(ST_MEMWR,  '0,        CARE_NONE, ST_FETCH,  c_wr);
        p[12] = mk_term(ST_RREXE,  '0,        CARE_NONE, ST_RRWB,   c_rrx);
        p[13] = mk_term(ST_RRWB,   '0,        CARE_NONE, ST_FETCH,  c_rrwb);
        p[14] = mk_term(ST_BRANCH, '0,        CARE_NONE, ST_FETCH,  c_br);
        p[15] = mk_term(ST_JUMP,   '0,        CARE_NONE, ST_FETCH,  c_jmp);
        p[16] = mk_term(ST_IMMEXE, '0,        CARE_NONE, ST_IMMWB,  c_imx);
        p[17] = mk_term(ST_IMMWB,  '0,        CARE_NONE, ST_FETCH,  c_imwb);
        return p;
    endfunction

endpackage

// File: rtl/mc_state_reg.sv
// State register: holds the current controller step.
// Assumes: synchronous active-low reset loads the fetch state (0).
module mc_state_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Load next state each edge, or clear to fetch under reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/mc_and_plane.sv
// AND plane: one match line per product term, comparing the exact state
// and the cared-for opcode bits of that term.
// Assumes: the table guarantees at most one line is high per input.
module mc_and_plane
    import mc_ctrl_pkg::*;
#(
    parameter int N = N_TERMS
) (
    input  logic [ST_W-1:0] state,
    input  logic [OP_W-1:0] opcode,
    output logic [N-1:0]    sel
);
    localparam plane_t PLANE = build_plane();

    for (genvar i = 0; i < N; i++) begin : g_term
        // Match line of term i
        assign sel[i] = (state == PLANE[i].st) &&
                        ((opcode & PLANE[i].care) == PLANE[i].op);
    end
endmodule

// File: rtl/mc_or_plane.sv
// OR plane: ORs the next-state and strobe columns of every selected term.
// Assumes: with no term selected the result is all zero (fetch, idle).
module mc_or_plane
    import mc_ctrl_pkg::*;
#(
    parameter int N = N_TERMS
) (
    input  logic [N-1:0]    sel,
    output logic [ST_W-1:0] ns,
    output ctrl_t           ctrl
);
    localparam plane_t PLANE = build_plane();

    // Wired-OR of the selected rows
    always_comb begin
        ns   = '0;
        ctrl = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) begin
                ns   = ns   | PLANE[i].ns;
                ctrl = ctrl | PLANE[i].ctrl;
            end
        end
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
// Multicycle controller top: state register plus two-plane product-term
// logic producing the next state and the datapath strobes.
// Assumes: opcode comes from the instruction register and is stable
// from decode until the instruction returns to fetch.
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    output logic [ST_W-1:0] state,
    output logic [ST_W-1:0] next_state,
    output logic            pc_write,
    output logic            pc_write_cond,
    output logic            iord,
    output logic            mem_write,
    output logic            ir_write,
    output logic            mem_to_reg,
    output logic [1:0]      pc_source,
    output logic [1:0]      alu_op,
    output logic [1:0]      alu_src_b,
    output logic            alu_src_a,
    output logic            reg_write,
    output logic            reg_dst,
    output logic            ext_op
);
    logic [N_TERMS-1:0] term_sel;
    ctrl_t              ctrl_w;

    mc_state_reg #(.W(ST_W)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (next_state),
        .q     (state)
    );

    mc_and_plane #(.N(N_TERMS)) u_and (
        .state  (state),
        .opcode (opcode),
        .sel    (term_sel)
    );

    mc_or_plane #(.N(N_TERMS)) u_or (
        .sel  (term_sel),
        .ns   (next_state),
        .ctrl (ctrl_w)
    );

    assign pc_write      = ctrl_w.pc_wr;
    assign pc_write_cond = ctrl_w.pc_wr_cond;
    assign iord          = ctrl_w.iord;
    assign mem_write     = ctrl_w.mem_wr;
    assign ir_write      = ctrl_w.ir_wr;
    assign mem_to_reg    = ctrl_w.mem_to_reg;
    assign pc_source     = ctrl_w.pc_src;
    assign alu_op        = ctrl_w.alu_op;
    assign alu_src_b     = ctrl_w.alu_src_b;
    assign alu_src_a     = ctrl_w.alu_src_a;
    assign reg_write     = ctrl_w.reg_wr;
    assign reg_dst       = ctrl_w.reg_dst;
    assign ext_op        = ctrl_w.ext_op;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
// Checker: cycle-by-cycle properties of the controller, bound to the top.
// Assumes: rst_n is held low for the first clock edge.
module mc_ctrl_fsm_chk
    import mc_ctrl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [OP_W-1:0]    opcode,
    input logic [ST_W-1:0]    state,
    input logic [ST_W-1:0]    next_state,
    input logic [N_TERMS-1:0] sel,
    input ctrl_t              ctrl
);
    a_r1_reset_to_fetch: assert property (@(posedge clk)
        !rst_n |=> state == ST_FETCH);

    a_r2_fetch_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH |-> next_state == ST_DECODE && ctrl.pc_wr && ctrl.ir_wr
                              && ctrl.alu_src_b == 2'b01 && !ctrl.reg_wr);

    a_r5_addr_to_read: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ADDR && opcode == OPC_LOAD |-> next_state == ST_MEMRD);

    a_r9_jump_done: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_JUMP |-> ctrl.pc_wr && ctrl.pc_src == 2'b10
                             && next_state == ST_FETCH && !ctrl.reg_wr);

    a_r11_regwrite_states: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.reg_wr |-> (state == ST_LDWB || state == ST_RRWB || state == ST_IMMWB));

    a_r12_single_term: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    a_r12_empty_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sel == '0 |-> next_state == ST_FETCH && ctrl == '0);

    a_r13_state_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> state == $past(next_state));
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (opcode),
    .state      (state),
    .next_state (next_state),
    .sel        (term_sel),
    .ctrl       (ctrl_w)
);

// File: tb/mc_ctrl_fsm_tb.sv
// Bench: directed instruction paths plus a seeded random opcode stream,
// every output compared with an independent model of the requirements.
module mc_ctrl_fsm_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    localparam logic [5:0] LD = 6'b100011, STO = 6'b101011, RR = 6'b000000;
    localparam logic [5:0] BEQ = 6'b000100, JMP = 6'b000010, ORI = 6'b001101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] opcode = '0;
    logic [3:0] state, next_state;
    logic pc_write, pc_write_cond, iord, mem_write, ir_write, mem_to_reg;
    logic [1:0] pc_source, alu_op, alu_src_b;
    logic alu_src_a, reg_write, reg_dst, ext_op;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] exp_st = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_ctrl_fsm u_dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .state(state),
        .next_state(next_state), .pc_write(pc_write), .pc_write_cond(pc_write_cond),
        .iord(iord), .mem_write(mem_write), .ir_write(ir_write),
        .mem_to_reg(mem_to_reg), .pc_source(pc_source), .alu_op(alu_op),
        .alu_src_b(alu_src_b), .alu_src_a(alu_src_a), .reg_write(reg_write),
        .reg_dst(reg_dst), .ext_op(ext_op)
    );

    // Model of the next state per requirements R3..R10, R4 and R12
    function automatic logic [3:0] model_ns(input logic [3:0] s, input logic [5:0] op);
        case (s)
            4'd0: return 4'd1;
            4'd1: case (op)
                      LD, STO: return 4'd2;
                      RR:      return 4'd6;
                      BEQ:     return 4'd8;
                      JMP:     return 4'd9;
                      ORI:     return 4'd10;
                      default: return 4'd0;
                  endcase
            4'd2: return (op == LD) ? 4'd3 : (op == STO) ? 4'd5 : 4'd0;
            4'd3: return 4'd4;
            4'd6: return 4'd7;
            4'd10: return 4'd11;
            default: return 4'd0;
        endcase
    endfunction

    // Model of strobes, packed {pcw,pcwc,iord,memw,irw,m2r,pcsrc,aluop,srcb,srca,regw,rdst,ext}
    function automatic logic [15:0] model_ctrl(input logic [3:0] s, input logic [5:0] op);
        logic pcw = 0, pcwc = 0, io = 0, mw = 0, irw = 0, m2r = 0;
        logic [1:0] psrc = 0, aop = 0, sb = 0;
        logic sa = 0, rw = 0, rd = 0, ex = 0;
        case (s)
            4'd0: begin pcw = 1; irw = 1; sb = 2'b01; end
            4'd1: if (model_ns(s, op) != 4'd0) begin sb = 2'b11; ex = 1; end
            4'd2: if (model_ns(s, op) != 4'd0) begin sa = 1; sb = 2'b10; ex = 1; end
            4'd3: io = 1;
            4'd4: begin rw = 1; m2r = 1; end
            4'd5: begin io = 1; mw = 1; end
            4'd6: begin sa = 1; aop = 2'b10; end
            4'd7: begin rw = 1; rd = 1; end
            4'd8: begin sa = 1; aop = 2'b01; pcwc = 1; psrc = 2'b01; end
            4'd9: begin pcw = 1; psrc = 2'b10; end
            4'd10: begin sa = 1; sb = 2'b10; aop = 2'b11; end
            4'd11: rw = 1;
            default: ;
        endcase
        return {pcw, pcwc, io, mw, irw, m2r, psrc, aop, sb, sa, rw, rd, ex};
    endfunction

    function automatic string req_of(input logic [3:0] s, input logic [5:0] op);
        case (s)
            4'd0: return "R2";
            4'd1: return (model_ns(s, op) == 4'd0) ? "R4" : "R3";
            4'd2: return (op == STO) ? "R6" : (op == LD) ? "R5" : "R12";
            4'd3, 4'd4: return "R5";
            4'd5: return "R6";
            4'd6, 4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (state %0d, opcode %b)",
                     req, got, exp, exp_st, opcode);
        end
    endtask

    // Apply one opcode for one cycle: check outputs, clock, advance model
    task automatic step(input logic [5:0] op);
        logic [15:0] got;
        opcode = op;
        #1;
        got = {pc_write, pc_write_cond, iord, mem_write, ir_write, mem_to_reg,
               pc_source, alu_op, alu_src_b, alu_src_a, reg_write, reg_dst, ext_op};
        check("R13", {12'd0, state}, {12'd0, exp_st});
        check(req_of(exp_st, op), got, model_ctrl(exp_st, op));
        check(req_of(exp_st, op), {12'd0, next_state}, {12'd0, model_ns(exp_st, op)});
        // R11: write strobe only in states 4, 7, 11
        check("R11", {15'd0, reg_write},
              {15'd0, (exp_st == 4'd4 || exp_st == 4'd7 || exp_st == 4'd11)});
        @(posedge clk);
        exp_st = model_ns(exp_st, op);
        @(negedge clk);
    endtask

    task automatic run_instr(input logic [5:0] op, input int cycles);
        for (int k = 0; k < cycles; k++) step(op);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        opcode = 6'h3f;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", {12'd0, state}, 16'd0);   // R1 reset state
        rst_n = 1'b1;
        exp_st = 4'd0;

        run_instr(LD, 5);     // R5 load 0,1,2,3,4
        run_instr(STO, 4);    // R6 store 0,1,2,5
        run_instr(RR, 4);     // R7
        run_instr(BEQ, 3);    // R8
        run_instr(JMP, 3);    // R9
        run_instr(ORI, 4);    // R10
        run_instr(6'b111111, 2);  // R4 unknown opcode in decode
        run_instr(6'b010101, 2);  // R4 another unknown opcode
        step(LD); step(LD);       // reach state 2
        step(RR);                 // R12 no term in state 2 -> fetch, all zero
        check("R12", {12'd0, state}, 16'd0);

        // R1: reset taken mid-instruction (state 6)
        step(RR); step(RR);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1", {12'd0, state}, 16'd0);
        rst_n = 1'b1;
        exp_st = 4'd0;

        // Random opcode stream, mostly legal codes
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] op;
            case ($urandom % 8)
                0: op = LD;  1: op = STO; 2: op = RR;  3: op = BEQ;
                4: op = JMP; 5: op = ORI; default: op = 6'($urandom);
            endcase
            step(op);
        end
        summary();
    end
endmodule